// File: doc/BRIEF.md
# Serial shift-register cascade output driver

This block drives a chain of up to three external 8-bit serial-in, parallel-out shift registers from three pins: a serial data line, a shift clock and a store strobe. A 24-bit output image is kept on chip. Software sets the image through a small register write port, together with a mask of the 8-bit groups that are actually fitted, a set of per-bit hardware takeover enables and the shift clock edge convention. The low eight bits of the image can be taken over bit by bit from on-chip status sources: a two-bit DSL status and two three-bit PHY status inputs.

A refresh writes the current image into the chain. It starts after any register write, after any change on a status input, or on an internal periodic tick. A change that arrives while a refresh is running is not lost: it causes exactly one more refresh after the running one. The enabled groups are sent highest group first and most significant bit first. One shift clock period is `DIV` system clocks, and a one-cycle store strobe follows the last bit.

Top module: `sipo_cascade_driver`

## Requirements
- R1: After reset the outputs `ser_data`, `ser_clk`, `ser_store` and `busy` are low. The image register holds `SHADOW_INIT`, all three groups are enabled, all takeover enables are clear and falling-edge mode is selected. The first refresh, from the periodic tick, stores `SHADOW_INIT` into the chain.
- R2: A write with `cfg_we` high uses `cfg_addr` to select the target. Address 0 loads the image from `cfg_wdata[23:0]`. Address 1 loads the group mask from `cfg_wdata[2:0]`, where bit g enables image bits 8g+7..8g. Address 2 loads the takeover enables from `cfg_wdata[7:0]`. Address 3 loads the edge mode from `cfg_wdata[0]`, where 1 selects rising-edge mode.
- R3: A refresh sends only the enabled groups, highest group first and each group MSB first, and gives exactly 8 sampling edges per enabled group. After the store, the external chain holds the enabled groups concatenated in that order.
- R4: Takeover enable bit b (b = 0..7) replaces image bit b with a source bit. Bits 0..1 come from `dsl_stat[1:0]`, bits 2..4 from `phy_a_stat[2:0]` and bits 5..7 from `phy_b_stat[2:0]`. Where the enable is clear, the software image bit is sent.
- R5: In falling-edge mode, data changes only when `ser_clk` falls and is stable across each rising edge, which is the sampling edge. In rising-edge mode the two edges swap roles, and data is stable across each falling edge.
- R6: `ser_store` is a single-cycle pulse that follows the last bit of a refresh. It is high only while `busy` is high.
- R7: `busy` is high from the first shift clock until the store pulse ends, and every shift clock edge falls inside that window.
- R8: A refresh is requested by any register write, by any change on a status input (even one whose enable is clear), and by the tick every `TICK_PERIOD` cycles.
- R9: A request made during a refresh causes one more refresh after the current one, so the chain ends holding the newest image.
- R10: With the group mask zero, no shift clock edges and no store pulse are produced, and `ser_data` and `busy` stay low.
- R11: Consecutive sampling edges within one refresh are `DIV` system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 24 | Register write data |
| dsl_stat | input | 2 | DSL status bits for image bits 1..0 |
| phy_a_stat | input | 3 | First PHY status bits for image bits 4..2 |
| phy_b_stat | input | 3 | Second PHY status bits for image bits 7..5 |
| ser_data | output | 1 | Serial data to the chain |
| ser_clk | output | 1 | Shift clock to the chain |
| ser_store | output | 1 | Store strobe to the chain |
| busy | output | 1 | Refresh in progress |

## Verification
The edge-stability properties assume that the edge mode does not change during a refresh. The design captures the mode when a refresh starts, so the properties are checked against that captured copy. The bench changes the mode only after the block has been idle for many cycles. The properties also assume that status inputs are synchronous to `clk`, and the bench drives them on the falling clock edge. The bench models the external chain: it shifts on the sampling edge of the current mode and latches on the store pulse. This lets it judge data order, edge counts and spacing purely from the pins.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    localparam int GRP_W = 8;
    localparam int N_GRP = 3;
    localparam int IMG_W = GRP_W * N_GRP;
    localparam int N_DSL = 2;
    localparam int N_PHY = 3;
    localparam int OVR_W = N_DSL + 2 * N_PHY;
    localparam int CNT_W = $clog2(IMG_W + 1);

    typedef logic [IMG_W-1:0] img_t;
    typedef logic [N_GRP-1:0] grp_t;

    typedef enum logic [1:0] {
        A_IMAGE  = 2'd0,
        A_GROUPS = 2'd1,
        A_TAKE   = 2'd2,
        A_EDGE   = 2'd3
    } addr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_STORE = 2'd2
    } st_t;

    // bit b of this struct lines up with image bit b
    typedef struct packed {
        logic [N_PHY-1:0] phy_b;
        logic [N_PHY-1:0] phy_a;
        logic [N_DSL-1:0] dsl;
    } take_t;

    typedef struct packed {
        img_t  image;
        grp_t  groups;
        take_t take_en;
        logic  edge_rise;
    } cfg_t;

    // enabled groups, highest first, left aligned in the result
    function automatic img_t pack_stream(img_t img, grp_t m);
        img_t s;
        int   k;
        s = '0;
        k = 0;
        for (int g = N_GRP - 1; g >= 0; g--) begin
            if (m[g]) begin
                s[IMG_W-1-GRP_W*k -: GRP_W] = img[g*GRP_W +: GRP_W];
                k++;
            end
        end
        return s;
    endfunction

    function automatic logic [CNT_W-1:0] stream_bits(grp_t m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int g = 0; g < N_GRP; g++) begin
            if (m[g]) n = n + CNT_W'(GRP_W);
        end
        return n;
    endfunction
endpackage

// File: rtl/sipo_cfg_regs.sv
module sipo_cfg_regs
    import sipo_pkg::*;
#(
    parameter img_t SHADOW_INIT = 24'h00FFFF,
    parameter grp_t GROUPS_INIT = 3'b111
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] addr,
    input  img_t       wdata,
    output cfg_t       cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.image     <= SHADOW_INIT;
            cfg.groups    <= GROUPS_INIT;
            cfg.take_en   <= '0;
            cfg.edge_rise <= 1'b0;
        end else if (we) begin
            case (addr_t'(addr))
                A_IMAGE:  cfg.image     <= wdata;
                A_GROUPS: cfg.groups    <= wdata[N_GRP-1:0];
                A_TAKE:   cfg.take_en   <= wdata[OVR_W-1:0];
                A_EDGE:   cfg.edge_rise <= wdata[0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/sipo_merge.sv
module sipo_merge
    import sipo_pkg::*;
(
    input  img_t  image,
    input  take_t take_en,
    input  take_t src,
    output img_t  merged
);
    logic [OVR_W-1:0] en_v;
    logic [OVR_W-1:0] src_v;

    assign en_v  = take_en;
    assign src_v = src;

    for (genvar b = 0; b < OVR_W; b++) begin : g_take
        assign merged[b] = en_v[b] ? src_v[b] : image[b];
    end

    assign merged[IMG_W-1:OVR_W] = image[IMG_W-1:OVR_W];
endmodule

// File: rtl/sipo_shifter.sv
module sipo_shifter
    import sipo_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  img_t             stream,
    input  logic [CNT_W-1:0] nbits,
    input  logic             edge_rise,
    output logic             ser_data,
    output logic             ser_clk,
    output logic             ser_store,
    output logic             busy,
    output logic             mode_o
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);

    st_t              state;
    logic [PH_W-1:0]  ph;
    logic [CNT_W-1:0] left;
    img_t             sreg;
    logic             mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ph    <= '0;
            left  <= '0;
            sreg  <= '0;
            mode  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        sreg  <= stream;
                        left  <= nbits;
                        ph    <= '0;
                        mode  <= edge_rise;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (ph == PH_LAST) begin
                        ph   <= '0;
                        sreg <= sreg << 1;
                        if (left == CNT_W'(1)) state <= ST_STORE;
                        else left <= left - CNT_W'(1);
                    end else begin
                        ph <= ph + PH_W'(1);
                    end
                end
                ST_STORE: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // falling mode: low then high within a bit; rising mode: high then low
    assign ser_data  = (state == ST_SHIFT) & sreg[IMG_W-1];
    assign ser_clk   = (state == ST_SHIFT) & ((ph >= PH_HALF) ^ mode);
    assign ser_store = (state == ST_STORE);
    assign busy      = (state != ST_IDLE);
    assign mode_o    = mode;
endmodule

// File: rtl/sipo_cascade_driver.sv
module sipo_cascade_driver
    import sipo_pkg::*;
#(
    parameter int   DIV         = 4,
    parameter int   TICK_PERIOD = 1024,
    parameter img_t SHADOW_INIT = 24'h00FFFF,
    parameter grp_t GROUPS_INIT = 3'b111
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [IMG_W-1:0] cfg_wdata,
    input  logic [N_DSL-1:0] dsl_stat,
    input  logic [N_PHY-1:0] phy_a_stat,
    input  logic [N_PHY-1:0] phy_b_stat,
    output logic             ser_data,
    output logic             ser_clk,
    output logic             ser_store,
    output logic             busy
);
    localparam int TW = (TICK_PERIOD > 2) ? $clog2(TICK_PERIOD) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_PERIOD - 1);

    cfg_t             cfg;
    take_t            src_now;
    take_t            src_q;
    img_t             merged;
    logic [TW-1:0]    tick_cnt;
    logic             tick;
    logic             req;
    logic             pend;
    logic             start;
    logic             shift_mode;

    sipo_cfg_regs #(
        .SHADOW_INIT(SHADOW_INIT),
        .GROUPS_INIT(GROUPS_INIT)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .addr (cfg_addr),
        .wdata(cfg_wdata),
        .cfg  (cfg)
    );

    assign src_now = {phy_b_stat, phy_a_stat, dsl_stat};
    assign tick    = (tick_cnt == TICK_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q    <= '0;
            tick_cnt <= '0;
            req      <= 1'b0;
            pend     <= 1'b0;
        end else begin
            src_q    <= src_now;
            tick_cnt <= tick ? '0 : tick_cnt + TW'(1);
            req      <= cfg_we | (src_now != src_q) | tick;
            if (!busy) pend <= 1'b0;
            else if (req) pend <= 1'b1;
        end
    end

    sipo_merge u_merge (
        .image  (cfg.image),
        .take_en(cfg.take_en),
        .src    (src_q),
        .merged (merged)
    );

    assign start = (req | pend) & (|cfg.groups);

    sipo_shifter #(.DIV(DIV)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stream   (pack_stream(merged, cfg.groups)),
        .nbits    (stream_bits(cfg.groups)),
        .edge_rise(cfg.edge_rise),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .ser_store(ser_store),
        .busy     (busy),
        .mode_o   (shift_mode)
    );
endmodule

// File: rtl/sipo_cascade_driver_chk.sv
module sipo_cascade_driver_chk (
    input logic clk,
    input logic rst,
    input logic ser_data,
    input logic ser_clk,
    input logic ser_store,
    input logic busy,
    input logic mode
);
    p_store_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        ser_store |=> !ser_store);

    p_store_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
        ser_store |-> busy);

    p_clk_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> busy);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_data && !ser_clk));

    p_fall_mode_stable_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(ser_clk) && !mode) |-> $stable(ser_data));

    p_rise_mode_stable_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(ser_clk) && mode) |-> $stable(ser_data));
endmodule

bind sipo_cascade_driver sipo_cascade_driver_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .ser_store(ser_store),
    .busy     (busy),
    .mode     (shift_mode)
);

// File: tb/sipo_cascade_driver_test.sv
module sipo_cascade_driver_test;
    localparam int DIV  = 4;
    localparam int TICK = 512;
    localparam logic [23:0] SH_INIT = 24'h00FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic [1:0]  dsl_stat = '0;
    logic [2:0]  phy_a_stat = '0;
    logic [2:0]  phy_b_stat = '0;
    logic        ser_data, ser_clk, ser_store, busy;

    sipo_cascade_driver #(.DIV(DIV), .TICK_PERIOD(TICK), .SHADOW_INIT(SH_INIT)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .dsl_stat(dsl_stat), .phy_a_stat(phy_a_stat),
        .phy_b_stat(phy_b_stat), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_store(ser_store), .busy(busy)
    );

    always #10 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    logic tb_rise = 1'b0;

    // external chain model, sampled away from the active edge
    int          cyc = 0;
    int          edge_cnt = 0, store_cnt = 0, period_err = 0, busy_err = 0;
    int          long_store = 0, act_cnt = 0, last_samp = 0;
    logic        have_last = 1'b0, prev_clk = 1'b0, prev_store = 1'b0;
    logic [23:0] ext_sreg = '0, latched = '0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            prev_clk <= 1'b0;
            prev_store <= 1'b0;
            have_last <= 1'b0;
        end else begin
            prev_clk <= ser_clk;
            prev_store <= ser_store;
            if (busy || ser_clk || ser_data || ser_store) act_cnt <= act_cnt + 1;
            if (tb_rise ? (prev_clk && !ser_clk) : (!prev_clk && ser_clk)) begin
                ext_sreg <= {ext_sreg[22:0], ser_data};
                edge_cnt <= edge_cnt + 1;
                if (have_last && (cyc - last_samp != DIV)) period_err <= period_err + 1;
                have_last <= 1'b1;
                last_samp <= cyc;
                if (!busy) busy_err <= busy_err + 1;
            end
            if (ser_clk != prev_clk && !busy) busy_err <= busy_err + 1;
            if (ser_store) begin
                latched <= ext_sreg;
                store_cnt <= store_cnt + 1;
                have_last <= 1'b0;
                if (prev_store) long_store <= long_store + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        int guard = 0;
        while (q < 60 && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (busy) q = 0;
            else q++;
        end
    endtask

    function automatic logic [23:0] exp_chain(input logic [23:0] img, input logic [2:0] m);
        logic [23:0] e = '0;
        for (int g = 2; g >= 0; g--)
            if (m[g]) e = (e << 8) | 24'(img[g*8 +: 8]);
        return e;
    endfunction

    function automatic logic [23:0] nmask(input logic [2:0] m);
        int n = 8 * ($countones(m));
        return (n == 24) ? 24'hFFFFFF : ((24'h1 << n) - 24'h1);
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int s0, e0, a0;
        logic [23:0] pat, exp_img;
        logic [7:0] src;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs after reset", {28'h0, ser_data, ser_clk, ser_store, busy}, 32'h0);
        // R1 and R8: first tick refresh stores the reset image
        begin
            int g = 0;
            while (store_cnt == 0 && g < 1000) begin @(negedge clk); g++; end
        end
        @(negedge clk);
        chk("R8 tick refresh occurred", store_cnt, 1);
        chk("R1 reset image stored", latched, SH_INIT);

        // R2 R3 R5: group mask sweep in both edge modes
        for (int md = 0; md < 2; md++) begin
            wait_quiet();
            tb_rise = md[0];
            wr(2'd3, 24'(md));
            wait_quiet();
            for (int m = 1; m < 8; m++) begin
                pat = (24'h5A3C96 + 24'(m) * 24'h010203) ^ (md ? 24'hFFF000 : 24'h0);
                wr(2'd1, 24'(m));
                wr(2'd0, pat);
                wait_quiet();
                chk($sformatf("R3 R5 chain contents mask=%0d mode=%0d", m, md),
                    latched & nmask(m[2:0]), exp_chain(pat, m[2:0]));
                s0 = store_cnt;
                e0 = edge_cnt;
                wr(2'd0, pat);
                wait_quiet();
                chk($sformatf("R3 edges per refresh mask=%0d mode=%0d", m, md),
                    edge_cnt - e0, 8 * $countones(m[2:0]) * (store_cnt - s0));
            end
        end
        chk("R11 sampling edge spacing errors", period_err, 0);
        chk("R7 edges outside busy", busy_err, 0);
        chk("R6 store longer than one cycle", long_store, 0);

        // R4: exhaustive takeover enable sweep on group 0 only
        tb_rise = 1'b0;
        wr(2'd3, 24'h0);
        wr(2'd1, 24'h1);
        wait_quiet();
        for (int e = 0; e < 256; e++) begin
            src = 8'((e * 37 + 11) & 255);
            pat = {16'h0, 8'(e) ^ 8'hC3};
            @(negedge clk);
            dsl_stat = src[1:0];
            phy_a_stat = src[4:2];
            phy_b_stat = src[7:5];
            wr(2'd2, 24'(e));
            wr(2'd0, pat);
            wait_quiet();
            exp_img = pat;
            for (int b = 0; b < 8; b++) if (e[b]) exp_img[b] = src[b];
            chk($sformatf("R4 takeover enable=%02h", e), latched[7:0], exp_img[7:0]);
        end

        // R8: change on a disabled source still refreshes, image unchanged
        wr(2'd2, 24'h0);
        wr(2'd0, 24'h0000A6);
        wait_quiet();
        s0 = store_cnt;
        @(negedge clk);
        phy_a_stat = ~phy_a_stat;
        repeat (45) @(negedge clk);
        chk("R8 source change starts refresh", 32'(store_cnt > s0), 1);
        chk("R8 disabled source leaves image", latched[7:0], 8'hA6);

        // R9: write during a refresh produces one more
        wr(2'd1, 24'h7);
        wait_quiet();
        s0 = store_cnt;
        wr(2'd0, 24'h123456);
        while (!busy) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R9 write lands during refresh", {31'h0, busy}, 1);
        wr(2'd0, 24'hFEDCBA);
        wait_quiet();
        chk("R9 newest image stored", latched, 24'hFEDCBA);
        chk("R9 two refreshes at least", 32'(store_cnt - s0 >= 2), 1);

        // R10: zero group mask
        wr(2'd1, 24'h0);
        wait_quiet();
        s0 = store_cnt;
        e0 = edge_cnt;
        a0 = act_cnt;
        wr(2'd0, 24'h0F0F0F);
        @(negedge clk);
        dsl_stat = 2'b11;
        phy_b_stat = 3'b101;
        repeat (600) @(negedge clk);
        chk("R10 no store with zero mask", store_cnt - s0, 0);
        chk("R10 no edges with zero mask", edge_cnt - e0, 0);
        chk("R10 pins idle with zero mask", act_cnt - a0, 0);

        finish_run();
    end
endmodule